// File: doc/BRIEF.md
# Command/Address Parity Checker

This block sits in the DRAM-side command path, between the command/address receivers and the command decoder. On every clock it looks at the command/address word and its parity bit. If checking is switched on, the word goes to the decoder only when its parity is correct. A good word is held back by a programmable parity latency of four to six clocks before it is released. A word with bad parity never reaches the decoder. Instead, a sticky error flag is set and the active-low alert output is pulled low for a programmable number of clocks.

If checking is switched off, words go straight through in the cycle they arrive, and the alert output stays high. Configuration comes in as plain levels: the enable, a two-bit latency code and an alert width. A one-cycle clear pulse resets the error flag. The command stream uses valid-only flow control. The checker offers no back-pressure, and the downstream decoder must accept every word on `exec_valid` in the cycle it is shown. The block does not stall or buffer beyond its latency line.

Top module: `cap_checker`

## Requirements
- R1: Parity is even. The count of ones over `in_ca` together with `in_par` must be even for a valid word to count as good. An odd count makes the word bad when checking is enabled.
- R2: With `chk_en` high, a good word presented with `in_valid` in cycle c appears on `exec_valid`/`exec_ca` in cycle c+L and in no other cycle. L is 4, 5 or 6 for `par_lat` codes 0, 1 or 2, and code 3 also gives 6. This holds only if `chk_en` stayed high from cycle c to cycle c+L.
- R3: With `chk_en` high, a bad word never appears on `exec_valid`.
- R4: A bad word in cycle c sets `err_sts` from cycle c+1. `err_sts` then stays set until a cycle with `err_clr` high and no new bad word, and it reads low from the following cycle. A bad word in the same cycle as `err_clr` leaves it set.
- R5: A bad word in cycle c, while `alert_n` is high, drives `alert_n` low for exactly W cycles, from c+1 to c+W. W is `alert_w` limited to the range 48 to 96, so smaller values give 48 and larger values give 96.
- R6: A bad word arriving while `alert_n` is low neither restarts nor lengthens the pulse in progress. It still sets `err_sts` and is still dropped.
- R7: With `chk_en` low, `exec_valid`/`exec_ca` equal `in_valid`/`in_ca` in the same cycle. `alert_n` stays high, and no word affects `err_sts`.
- R8: Dropping `chk_en` ends any alert pulse at once. It also discards every word still waiting in the latency line, so none of them is ever released.
- R9: While `rst_n` is low, `exec_valid` is low when `in_valid` is low, `alert_n` is high and `err_sts` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en | input | 1 | Parity checking enable |
| par_lat | input | 2 | Latency code: 0→4, 1→5, 2→6, 3→6 cycles |
| alert_w | input | 7 | Alert pulse width in cycles, limited to 48..96 |
| err_clr | input | 1 | One-cycle clear of the error flag |
| in_valid | input | 1 | Incoming word is valid |
| in_ca | input | CA_W (24) | Incoming command/address bits |
| in_par | input | 1 | Incoming even-parity bit |
| exec_valid | output | 1 | Released word is valid this cycle |
| exec_ca | output | CA_W (24) | Released command/address bits |
| alert_n | output | 1 | Active-low parity alert |
| err_sts | output | 1 | Sticky parity error flag |

## Verification
The bench uses the default parameters: a 24-bit word, a latency range of 4 to 6 and a width range of 48 to 96. Because the alert width is a 7-bit port, the values 20 and 127 can be driven to test the limiting at both ends. All four latency codes are run, and so are widths at both limits. Each alert pulse is compared cycle by cycle, so its length is checked exactly. Directed sequences cover a second error inside a pulse, a clear colliding with an error, and checking being switched off partway through a pulse.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    LAT_CODE_A = 2'd0,
    LAT_CODE_B = 2'd1,
    LAT_CODE_C = 2'd2,
    LAT_CODE_D = 2'd3
  } lat_code_e;

  // Cycles of latency for a code, saturated at the upper bound.
  function automatic int lat_cycles(input lat_code_e code, input int lo, input int hi);
    int n;
    n = lo + int'(code);
    if (n > hi) n = hi;
    return n;
  endfunction

endpackage

// File: rtl/cap_parity.sv
module cap_parity #(
  parameter int W = 24
) (
  input  logic [W-1:0] ca,
  input  logic         par,
  output logic         odd
);
  // Even parity: an odd total count marks the word as corrupt.
  assign odd = ^{ca, par};
endmodule

// File: rtl/cap_delay_line.sv
module cap_delay_line #(
  parameter int W     = 24,
  parameter int DEPTH = 6,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_v,
  input  logic [W-1:0]  in_d,
  input  logic [IW-1:0] sel,
  output logic          out_v,
  output logic [W-1:0]  out_d
);
  logic [DEPTH-1:0] stg_v;
  logic [W-1:0]     stg_d [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic         nxt_v;
    logic [W-1:0] nxt_d;
    if (i == 0) begin : g_head
      assign nxt_v = in_v;
      assign nxt_d = in_d;
    end else begin : g_body
      assign nxt_v = stg_v[i-1];
      assign nxt_d = stg_d[i-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        stg_v[i] <= 1'b0;
        stg_d[i] <= '0;
      end else begin
        stg_v[i] <= nxt_v;
        stg_d[i] <= nxt_d;
      end
    end
  end

  assign out_v = stg_v[sel];
  assign out_d = stg_d[sel];
endmodule

// File: rtl/cap_alert_timer.sv
module cap_alert_timer #(
  parameter int AW_MIN  = 48,
  parameter int AW_MAX  = 96,
  parameter int AW_BITS = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               trig,
  input  logic [AW_BITS-1:0] width,
  output logic               alert_n
);
  logic [AW_BITS-1:0] remain;
  logic [AW_BITS-1:0] w_eff;

  always_comb begin
    if (width < AW_BITS'(AW_MIN))      w_eff = AW_BITS'(AW_MIN);
    else if (width > AW_BITS'(AW_MAX)) w_eff = AW_BITS'(AW_MAX);
    else                               w_eff = width;
  end

  // A trigger only arms an idle timer; a running pulse is left alone.
  always_ff @(posedge clk) begin
    if (!rst_n || !en)  remain <= '0;
    else if (remain != '0) remain <= remain - 1'b1;
    else if (trig)      remain <= w_eff;
  end

  assign alert_n = !(en && (remain != '0));
endmodule

// File: rtl/cap_checker.sv
module cap_checker
  import cap_pkg::*;
#(
  parameter int CA_W    = 24,
  parameter int LAT_MIN = 4,
  parameter int LAT_MAX = 6,
  parameter int AW_MIN  = 48,
  parameter int AW_MAX  = 96,
  localparam int AW_BITS = $clog2(AW_MAX + 1),
  localparam int SEL_W   = (LAT_MAX > 1) ? $clog2(LAT_MAX) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chk_en,
  input  logic [1:0]         par_lat,
  input  logic [AW_BITS-1:0] alert_w,
  input  logic               err_clr,
  input  logic               in_valid,
  input  logic [CA_W-1:0]    in_ca,
  input  logic               in_par,
  output logic               exec_valid,
  output logic [CA_W-1:0]    exec_ca,
  output logic               alert_n,
  output logic               err_sts
);
  logic            odd;
  logic            bad;
  logic            good;
  logic [SEL_W-1:0] tap;
  logic            dl_v;
  logic [CA_W-1:0] dl_d;
  logic            err_q;

  cap_parity #(.W(CA_W)) u_par (
    .ca  (in_ca),
    .par (in_par),
    .odd (odd)
  );

  assign bad  = chk_en && in_valid && odd;
  assign good = chk_en && in_valid && !odd;

  always_comb begin
    int n;
    n   = lat_cycles(lat_code_e'(par_lat), LAT_MIN, LAT_MAX);
    tap = SEL_W'(n - 1);
  end

  cap_delay_line #(.W(CA_W), .DEPTH(LAT_MAX)) u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (!chk_en),
    .in_v  (good),
    .in_d  (in_ca),
    .sel   (tap),
    .out_v (dl_v),
    .out_d (dl_d)
  );

  cap_alert_timer #(.AW_MIN(AW_MIN), .AW_MAX(AW_MAX), .AW_BITS(AW_BITS)) u_alert (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (chk_en),
    .trig    (bad),
    .width   (alert_w),
    .alert_n (alert_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (bad)     err_q <= 1'b1;
    else if (err_clr) err_q <= 1'b0;
  end

  assign err_sts    = err_q;
  assign exec_valid = chk_en ? dl_v : in_valid;
  assign exec_ca    = chk_en ? dl_d : in_ca;
endmodule

// File: rtl/cap_checker_sva.sv
module cap_checker_sva #(
  parameter int CA_W    = 24,
  parameter int AW_BITS = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               chk_en,
  input logic               err_clr,
  input logic               in_valid,
  input logic [CA_W-1:0]    in_ca,
  input logic               in_par,
  input logic               exec_valid,
  input logic               alert_n,
  input logic               err_sts
);
  logic hit;
  assign hit = chk_en && in_valid && (^{in_ca, in_par});

  // R7
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |-> (exec_valid == in_valid));

  // R7
  quiet_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |-> alert_n);

  // R4
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> err_sts);

  // R4
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sts && !err_clr) |=> err_sts);

  // R4
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_sts) |-> $past(hit));

  // R5
  alert_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_n) |-> $past(hit));
endmodule

bind cap_checker cap_checker_sva #(.CA_W(CA_W), .AW_BITS(AW_BITS)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .chk_en     (chk_en),
  .err_clr    (err_clr),
  .in_valid   (in_valid),
  .in_ca      (in_ca),
  .in_par     (in_par),
  .exec_valid (exec_valid),
  .alert_n    (alert_n),
  .err_sts    (err_sts)
);

// File: tb/cap_checker_tb_top.sv
module cap_checker_tb_top;
  localparam int CA_W = 24;
  localparam int HN   = 8192;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            chk_en = 1'b0;
  logic [1:0]      par_lat = 2'd0;
  logic [6:0]      alert_w = 7'd48;
  logic            err_clr = 1'b0;
  logic            in_valid = 1'b0;
  logic [CA_W-1:0] in_ca = '0;
  logic            in_par = 1'b0;
  logic            exec_valid;
  logic [CA_W-1:0] exec_ca;
  logic            alert_n;
  logic            err_sts;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cap_checker dut_i (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .par_lat(par_lat),
    .alert_w(alert_w), .err_clr(err_clr), .in_valid(in_valid),
    .in_ca(in_ca), .in_par(in_par), .exec_valid(exec_valid),
    .exec_ca(exec_ca), .alert_n(alert_n), .err_sts(err_sts)
  );

  // Bench-side history and reference state.
  bit            en_h  [HN];
  bit            v_h   [HN];
  bit            odd_h [HN];
  bit [CA_W-1:0] ca_h  [HN];
  int  c = 0;
  int  m_cnt = 0;
  bit  m_err = 0;
  bit  m_extra = 0;
  bit  last_bad = 0;

  function automatic int lat_of(input logic [1:0] code);
    return (code == 2'd0) ? 4 : (code == 2'd1) ? 5 : 6;
  endfunction

  function automatic int width_of(input logic [6:0] w);
    if (w < 7'd48) return 48;
    if (w > 7'd96) return 96;
    return int'(w);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, c, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [CA_W-1:0] ca, input bit flip, input bit clr);
    int  lat;
    bit  win;
    bit  ev;
    bit  eal;
    bit  b;
    string t;
    in_valid = v; in_ca = ca; in_par = (^ca) ^ flip; err_clr = clr;
    en_h[c] = chk_en; v_h[c] = v; odd_h[c] = flip; ca_h[c] = ca;
    @(negedge clk);
    lat = lat_of(par_lat);
    if (chk_en) begin
      win = (c >= lat);
      for (int k = c - lat; k <= c; k++) if (k < 0 || !en_h[k]) win = 0;
      ev = win && v_h[c-lat] && !odd_h[c-lat];
      if (win && v_h[c-lat] && odd_h[c-lat]) t = "R3";
      else if (!win && c >= lat) t = "R8";
      else t = "R2";
      check(exec_valid == ev, t, 64'(exec_valid), 64'(ev));
      if (ev) check(exec_ca == ca_h[c-lat], "R2", 64'(exec_ca), 64'(ca_h[c-lat]));
    end else begin
      check(exec_valid == v, "R7", 64'(exec_valid), 64'(v));
      if (v) check(exec_ca == ca, "R7", 64'(exec_ca), 64'(ca));
    end
    eal = !(chk_en && m_cnt != 0);
    if (!chk_en) t = (m_cnt != 0) ? "R8" : "R7";
    else t = m_extra ? "R6" : "R5";
    check(alert_n == eal, t, 64'(alert_n), 64'(eal));
    check(err_sts == m_err, last_bad ? "R1" : "R4", 64'(err_sts), 64'(m_err));
    @(posedge clk);
    b = chk_en && v && flip;
    if (!chk_en) begin m_cnt = 0; m_extra = 0; end
    else if (m_cnt != 0) begin
      if (b) m_extra = 1;
      m_cnt--;
      if (m_cnt == 0) m_extra = 0;
    end else if (b) m_cnt = width_of(alert_w);
    if (b) m_err = 1; else if (clr) m_err = 0;
    last_bad = b;
    c++;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic rand_run(input int n, input int bad_pct);
    for (int i = 0; i < n; i++)
      step(($urandom % 10) < 7, CA_W'($urandom), ($urandom % 100) < bad_pct, ($urandom % 50) == 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    chk_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    check(exec_valid == 1'b0, "R9", 64'(exec_valid), 64'd0);
    check(alert_n == 1'b1, "R9", 64'(alert_n), 64'd1);
    check(err_sts == 1'b0, "R9", 64'(err_sts), 64'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R2 single good word, latency 4
    par_lat = 2'd0;
    step(1'b1, 24'h00A5A5, 1'b0, 1'b0);
    idle(8);
    // R1 / R5 single bad word with minimum width
    alert_w = 7'd48;
    step(1'b1, 24'h123456, 1'b1, 1'b0);
    idle(20);
    // R6 second bad word inside the pulse
    step(1'b1, 24'h0F0F0F, 1'b1, 1'b0);
    idle(40);
    // R4 clear, then clear colliding with a bad word
    step(1'b0, '0, 1'b0, 1'b1);
    idle(2);
    step(1'b1, 24'h000001, 1'b1, 1'b1);
    idle(100);
    step(1'b0, '0, 1'b0, 1'b1);
    idle(2);
    // R8 disable mid-pulse and mid-flight
    step(1'b1, 24'hABCDEF, 1'b1, 1'b0);
    step(1'b1, 24'h111111, 1'b0, 1'b0);
    idle(5);
    chk_en = 1'b0;
    step(1'b0, '0, 1'b0, 1'b0);
    chk_en = 1'b1;
    idle(10);

    // Random phases across latency codes and widths (R2 R3 R5)
    for (int ph = 0; ph < 8; ph++) begin
      chk_en = 1'b0;
      step(1'b0, '0, 1'b0, 1'b0);
      par_lat = 2'(ph % 4);
      case (ph / 2)
        0: alert_w = 7'd48;
        1: alert_w = 7'd96;
        2: alert_w = 7'd20;
        default: alert_w = 7'd127;
      endcase
      chk_en = 1'b1;
      rand_run(350, 2);
    end

    // R7 checking off: bypass and no effect on status
    chk_en = 1'b0;
    rand_run(300, 30);
    chk_en = 1'b1;
    rand_run(200, 3);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule